// File: doc/BRIEF.md
# Conversion and fetch trigger generator

This block paces a successive-approximation converter and the engine that reads its results. It drives the converter's conversion-start input with a periodic pulse train. It also raises a one-cycle fetch trigger that tells a serial read engine when a finished result is ready. Software chooses an output sample rate and an averaging exponent N. The conversion pulses then run 2^N times faster than the output rate, and one fetch happens for each completed averaging frame of 2^N conversions.

Every setting is validated before it takes effect. The conversion period is computed in clock cycles as the rounded ratio of the clock frequency to the conversion rate. A rate of zero, a rate above the part maximum, an exponent above 16, or a period shorter than the minimum conversion cycle is refused. When a setting is refused, the error flag is raised and the running configuration stays as it was. The pulse high time and the fetch delay after the conversion edge are rounded up onto the clock grid, so neither can fall below its 10 ns floor.

Top module: `conv_fetch_gen`

## Requirements
- R1: After reset both pulse outputs and the error flag are low. The configuration defaults to an output rate of MAX_RATE_HZ/16 (125 kHz) with N = 0, so on enable the conversion period is 2000 cycles of the 250 MHz clock.
- R2: A write to address 0 sets the output rate in Hz and a write to address 1 sets N (the full data word). The conversion period becomes round(CLK_HZ / (rate * 2^N)) cycles, with halves rounded up.
- R3: Each conversion pulse is high for exactly 3 cycles (12 ns). This is the 10 ns minimum, raised in 10 ns steps until it lands on the clock grid.
- R4: A fetch pulse is one cycle wide. Between two successive fetch pulses there are exactly 2^N rising conversion edges.
- R5: A fetch pulse comes 3 cycles (at least 10 ns of quiet time) after a rising conversion edge, and it never overlaps a high conversion pulse.
- R6: A write is rejected if it gives a rate of 0, a rate above MAX_RATE_HZ (2 MHz), an N above 16, or a period below 125 cycles (500 ns). A rejected write sets the error flag, and the previous period and frame length keep running.
- R7: An accepted write clears the error flag. Changing N recomputes the period from the currently held output rate.
- R8: After enable from idle, or after a new configuration is applied, counting restarts. The first fetch comes only after a full frame: it follows the (2^N+1)-th rising conversion edge.
- R9: On enable the conversion train starts first. Once the clock edge samples the enable low, no fetch pulse and no new rising conversion edge appear. A conversion pulse already in progress still completes its full 3-cycle width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock (CLK_HZ) |
| rst_n | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run enable for the pulse trains |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 selects the output rate, 1 selects the averaging exponent |
| cfg_wdata_i | input | CFG_DW | Configuration write data |
| conv_o | output | 1 | Conversion-start pulse train |
| fetch_o | output | 1 | One-cycle result fetch trigger |
| cfg_err_o | output | 1 | Set when the last evaluated write was rejected |

## Verification
The embedded assertions check the following on every cycle:
- a conversion pulse is never narrower than its floor;
- fetch and conversion never overlap, and a fetch lasts one cycle;
- neither a fetch nor a new conversion edge follows a sampled-low enable;
- the held period never drops under the cycle-time floor;
- a rejection leaves the held period and exponent unchanged.

Only the bench scenarios can show the values themselves:
- the rounded period for a given rate and exponent;
- the count of 2^N conversions per frame and the 3-cycle fetch offset;
- whether the right settings are refused;
- the full frame before the first fetch after a restart.

// File: rtl/cft_pkg.sv
`timescale 1ns/1ps
package cft_pkg;

    typedef enum logic {
        CFG_IDLE = 1'b0,
        CFG_WAIT = 1'b1
    } cfg_state_e;

    // Ceiling division for elaboration-time constants.
    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Smallest clock-grid count whose length reaches min_ns, trying
    // targets that grow in min_ns steps and rounding each to nearest.
    function automatic int grid_cycles(input int min_ns, input int clk_ns);
        int target;
        int cyc;
        int res;
        res    = 0;
        target = min_ns;
        for (int i = 0; i < 32; i++) begin
            cyc = (target + clk_ns / 2) / clk_ns;
            if (res == 0 && cyc * clk_ns >= min_ns) res = cyc;
            target = target + min_ns;
        end
        return res;
    endfunction

endpackage

// File: rtl/conv_fetch_div.sv
`timescale 1ns/1ps
module conv_fetch_div #(
    parameter int NUM_W = 38,
    parameter int DEN_W = 37
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
    } div_t;

    div_t q, d;
    logic [DEN_W:0] rem_sh;
    logic           fits;

    assign rem_sh = {q.rem, q.num[NUM_W-1]};
    assign fits   = (rem_sh >= {1'b0, den_i});

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = CNT_W'(NUM_W);
            d.num  = num_i;
            d.rem  = '0;
            d.quo  = '0;
        end else if (q.busy) begin
            d.rem = fits ? DEN_W'(rem_sh - {1'b0, den_i}) : rem_sh[DEN_W-1:0];
            d.quo = {q.quo[NUM_W-2:0], fits};
            d.num = q.num << 1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;

    // R2
    div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(q.busy));

    // R2
    div_start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !q.busy);

endmodule

// File: rtl/conv_fetch_cfg.sv
`timescale 1ns/1ps
module conv_fetch_cfg
    import cft_pkg::*;
#(
    parameter int CFG_DW       = 32,
    parameter int RATE_W       = 21,
    parameter int NAVG_W       = 5,
    parameter int DEN_W        = 37,
    parameter int NUM_W        = 38,
    parameter int PER_W        = 28,
    parameter int CLK_HZ       = 250_000_000,
    parameter int MAX_RATE_HZ  = 2_000_000,
    parameter int MAX_AVG_LOG2 = 16,
    parameter int MIN_CYC      = 125,
    parameter int DEF_RATE     = 125_000,
    parameter int DEF_PER      = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              addr_i,
    input  logic [CFG_DW-1:0] wdata_i,
    output logic              div_start_o,
    output logic [DEN_W-1:0]  div_den_o,
    output logic [NUM_W-1:0]  div_num_o,
    input  logic              div_done_i,
    input  logic [NUM_W-1:0]  div_quo_i,
    output logic              apply_o,
    output logic [PER_W-1:0]  period_o,
    output logic [NAVG_W-1:0] navg_o,
    output logic              err_o
);
    typedef struct packed {
        cfg_state_e        state;
        logic [RATE_W-1:0] rate;
        logic [NAVG_W-1:0] navg;
        logic [PER_W-1:0]  period;
        logic [RATE_W-1:0] cand_rate;
        logic [NAVG_W-1:0] cand_navg;
        logic [DEN_W-1:0]  den;
        logic              start;
        logic              apply;
        logic              err;
    } cfg_t;

    cfg_t q, d;
    logic [CFG_DW-1:0] rate_w;
    logic [CFG_DW-1:0] navg_w;
    logic              legal;
    logic              quo_ok;

    assign rate_w = addr_i ? CFG_DW'(q.rate) : wdata_i;
    assign navg_w = addr_i ? wdata_i : CFG_DW'(q.navg);
    assign legal  = (rate_w != '0) && (rate_w <= CFG_DW'(MAX_RATE_HZ))
                 && (navg_w <= CFG_DW'(MAX_AVG_LOG2));
    assign quo_ok = (div_quo_i >= NUM_W'(MIN_CYC)) && ((div_quo_i >> PER_W) == '0);

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.apply = 1'b0;
        case (q.state)
            CFG_IDLE: begin
                if (we_i) begin
                    if (!legal) begin
                        d.err = 1'b1;
                    end else begin
                        d.cand_rate = rate_w[RATE_W-1:0];
                        d.cand_navg = navg_w[NAVG_W-1:0];
                        d.den       = DEN_W'(rate_w[RATE_W-1:0]) << navg_w[NAVG_W-1:0];
                        d.start     = 1'b1;
                        d.state     = CFG_WAIT;
                    end
                end
            end
            CFG_WAIT: begin
                if (div_done_i) begin
                    d.state = CFG_IDLE;
                    if (quo_ok) begin
                        d.rate   = q.cand_rate;
                        d.navg   = q.cand_navg;
                        d.period = div_quo_i[PER_W-1:0];
                        d.apply  = 1'b1;
                        d.err    = 1'b0;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            default: d.state = CFG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= CFG_IDLE;
            q.rate   <= RATE_W'(DEF_RATE);
            q.period <= PER_W'(DEF_PER);
        end else begin
            q <= d;
        end
    end

    assign div_start_o = q.start;
    assign div_den_o   = q.den;
    assign div_num_o   = NUM_W'(CLK_HZ) + NUM_W'(q.den >> 1);
    assign apply_o     = q.apply;
    assign period_o    = q.period;
    assign navg_o      = q.navg;
    assign err_o       = q.err;

    // R6
    period_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.period >= PER_W'(MIN_CYC));

    // R6
    reject_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.err) |-> ($stable(q.period) && $stable(q.navg)));

    // R2
    navg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.navg <= NAVG_W'(MAX_AVG_LOG2));

endmodule

// File: rtl/conv_fetch_pgen.sv
`timescale 1ns/1ps
module conv_fetch_pgen #(
    parameter int PER_W     = 28,
    parameter int FRM_W     = 16,
    parameter int NAVG_W    = 5,
    parameter int HIGH_CYC  = 3,
    parameter int QUIET_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              restart_i,
    input  logic [PER_W-1:0]  period_i,
    input  logic [NAVG_W-1:0] navg_i,
    output logic              conv_o,
    output logic              fetch_o
);
    localparam int HR_W = $clog2(HIGH_CYC + 1) + 1;

    typedef struct packed {
        logic             active;
        logic             drain;
        logic             armed;
        logic [PER_W-1:0] phase;
        logic [FRM_W-1:0] frame;
    } pg_t;

    pg_t q, d;
    logic [FRM_W:0] span;
    logic           frame_last;
    logic           wrap;
    logic           hi_done;

    assign span       = (FRM_W+1)'(1) << navg_i;
    assign frame_last = ({1'b0, q.frame} == span - 1'b1);
    assign wrap       = (q.phase == period_i - 1'b1);
    assign hi_done    = (q.phase >= PER_W'(HIGH_CYC - 1));

    always_comb begin
        d = q;
        if (!q.active) begin
            if (en_i) begin
                d.active = 1'b1;
                d.drain  = 1'b0;
                d.armed  = 1'b0;
                d.phase  = '0;
                d.frame  = '0;
            end
        end else if (q.drain || !en_i) begin
            if (hi_done) begin
                d.active = 1'b0;
                d.drain  = 1'b0;
            end else begin
                d.drain = 1'b1;
                d.phase = q.phase + 1'b1;
            end
        end else if (restart_i) begin
            d.phase = '0;
            d.frame = '0;
            d.armed = 1'b0;
        end else if (wrap) begin
            d.phase = '0;
            if (frame_last) begin
                d.frame = '0;
                d.armed = 1'b1;
            end else begin
                d.frame = q.frame + 1'b1;
            end
        end else begin
            d.phase = q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign conv_o  = q.active && (q.phase < PER_W'(HIGH_CYC));
    assign fetch_o = q.active && !q.drain && q.armed && (q.frame == '0)
                  && (q.phase == PER_W'(QUIET_CYC));

    // Run length of the current conversion high pulse, for the width check.
    logic [HR_W-1:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_run_q <= '0;
        else if (!conv_o)                   hi_run_q <= '0;
        else if (hi_run_q < HR_W'(HIGH_CYC)) hi_run_q <= hi_run_q + 1'b1;
    end

    // R3
    conv_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_o) |-> (hi_run_q >= HR_W'(HIGH_CYC)));

    // R9
    conv_rise_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_o) |-> $past(en_i));

    // R9
    fetch_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> $past(en_i));

    // R4
    fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> !fetch_o);

    // R5
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> !conv_o);

endmodule

// File: rtl/conv_fetch_gen.sv
`timescale 1ns/1ps
module conv_fetch_gen
    import cft_pkg::*;
#(
    parameter int CLK_HZ       = 250_000_000,
    parameter int MAX_RATE_HZ  = 2_000_000,
    parameter int MIN_CYCLE_NS = 500,
    parameter int MIN_HIGH_NS  = 10,
    parameter int QUIET_NS     = 10,
    parameter int MAX_AVG_LOG2 = 16,
    parameter int CFG_DW       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cfg_we_i,
    input  logic              cfg_addr_i,
    input  logic [CFG_DW-1:0] cfg_wdata_i,
    output logic              conv_o,
    output logic              fetch_o,
    output logic              cfg_err_o
);
    localparam int CLK_NS    = 1_000_000_000 / CLK_HZ;
    localparam int MIN_CYC   = ceil_div(MIN_CYCLE_NS, CLK_NS);
    localparam int HIGH_CYC  = grid_cycles(MIN_HIGH_NS, CLK_NS);
    localparam int QUIET_CYC = grid_cycles(QUIET_NS, CLK_NS);
    localparam int RATE_W    = $clog2(MAX_RATE_HZ + 1);
    localparam int NAVG_W    = $clog2(MAX_AVG_LOG2 + 1);
    localparam int DEN_W     = RATE_W + MAX_AVG_LOG2;
    localparam int PER_W     = $clog2(CLK_HZ + 1);
    localparam int NUM_W     = ((DEN_W > PER_W) ? DEN_W : PER_W) + 1;
    localparam int FRM_W     = (MAX_AVG_LOG2 > 0) ? MAX_AVG_LOG2 : 1;
    localparam int DEF_RATE  = MAX_RATE_HZ / 16;
    localparam int DEF_PER   = (CLK_HZ + DEF_RATE / 2) / DEF_RATE;

    logic              div_start;
    logic [DEN_W-1:0]  div_den;
    logic [NUM_W-1:0]  div_num;
    logic              div_done;
    logic [NUM_W-1:0]  div_quo;
    logic              apply;
    logic [PER_W-1:0]  period;
    logic [NAVG_W-1:0] navg;

    conv_fetch_cfg #(
        .CFG_DW      (CFG_DW),
        .RATE_W      (RATE_W),
        .NAVG_W      (NAVG_W),
        .DEN_W       (DEN_W),
        .NUM_W       (NUM_W),
        .PER_W       (PER_W),
        .CLK_HZ      (CLK_HZ),
        .MAX_RATE_HZ (MAX_RATE_HZ),
        .MAX_AVG_LOG2(MAX_AVG_LOG2),
        .MIN_CYC     (MIN_CYC),
        .DEF_RATE    (DEF_RATE),
        .DEF_PER     (DEF_PER)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (cfg_we_i),
        .addr_i     (cfg_addr_i),
        .wdata_i    (cfg_wdata_i),
        .div_start_o(div_start),
        .div_den_o  (div_den),
        .div_num_o  (div_num),
        .div_done_i (div_done),
        .div_quo_i  (div_quo),
        .apply_o    (apply),
        .period_o   (period),
        .navg_o     (navg),
        .err_o      (cfg_err_o)
    );

    conv_fetch_div #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(div_start),
        .num_i  (div_num),
        .den_i  (div_den),
        .done_o (div_done),
        .quo_o  (div_quo)
    );

    conv_fetch_pgen #(
        .PER_W    (PER_W),
        .FRM_W    (FRM_W),
        .NAVG_W   (NAVG_W),
        .HIGH_CYC (HIGH_CYC),
        .QUIET_CYC(QUIET_CYC)
    ) u_pgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .restart_i(apply),
        .period_i (period),
        .navg_i   (navg),
        .conv_o   (conv_o),
        .fetch_o  (fetch_o)
    );

endmodule

// File: tb/sim_conv_fetch_gen.sv
`timescale 1ns/1ps
module sim_conv_fetch_gen;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic        en    = 1'b0;
    logic        we    = 1'b0;
    logic        addr  = 1'b0;
    logic [31:0] wdata = '0;
    wire         conv;
    wire         fetch;
    wire         err;

    int checks   = 0;
    int errors   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    conv_fetch_gen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en),
        .cfg_we_i   (we),
        .cfg_addr_i (addr),
        .cfg_wdata_i(wdata),
        .conv_o     (conv),
        .fetch_o    (fetch),
        .cfg_err_o  (err)
    );

    // {addr, data[31:0], expected error, expected period[31:0], held N[7:0]}
    localparam int NV = 14;
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 32'd1000000, 1'b0, 32'd250, 8'd0},
        {1'b1, 32'd1,       1'b0, 32'd125, 8'd1},
        {1'b0, 32'd1900000, 1'b1, 32'd125, 8'd1},
        {1'b1, 32'd0,       1'b0, 32'd250, 8'd0},
        {1'b0, 32'd1900000, 1'b0, 32'd132, 8'd0},
        {1'b0, 32'd0,       1'b1, 32'd132, 8'd0},
        {1'b0, 32'd2000001, 1'b1, 32'd132, 8'd0},
        {1'b0, 32'd2000000, 1'b0, 32'd125, 8'd0},
        {1'b0, 32'd300000,  1'b0, 32'd833, 8'd0},
        {1'b1, 32'd2,       1'b0, 32'd208, 8'd2},
        {1'b1, 32'd17,      1'b1, 32'd208, 8'd2},
        {1'b1, 32'd3,       1'b1, 32'd208, 8'd2},
        {1'b0, 32'd250000,  1'b0, 32'd250, 8'd2},
        {1'b1, 32'd3,       1'b0, 32'd125, 8'd3}
    };

    task automatic check_eq(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input bit a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic next_rise(output int n);
        bit prev;
        prev = conv;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (conv && !prev) break;
            prev = conv;
        end
    endtask

    task automatic high_width(output int w);
        w = 1;
        forever begin
            @(negedge clk);
            if (!conv) break;
            w++;
        end
    endtask

    // Counts rising conversion edges up to the next fetch and the cycles
    // from the last such edge to the fetch.
    task automatic rises_to_fetch(output int rises, output int since);
        bit prev;
        prev  = conv;
        rises = 0;
        since = 0;
        forever begin
            @(negedge clk);
            if (conv && !prev) begin
                rises++;
                since = 0;
            end else begin
                since++;
            end
            prev = conv;
            if (fetch) break;
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int n, p, w, r, s, hits;
        logic [73:0] v;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check_eq("R1 conv after reset", conv, 0);
        check_eq("R1 fetch after reset", fetch, 0);
        check_eq("R1 err after reset", err, 0);

        // R8 first fetch after a full frame from enable (N=0 -> 2 edges)
        @(negedge clk);
        en = 1'b1;
        rises_to_fetch(r, s);
        check_eq("R8 edges before first fetch N=0", r, 2);
        check_eq("R5 fetch delay after edge", s, 3);
        next_rise(n);
        next_rise(p);
        check_eq("R1 default period", p, 2000);
        high_width(w);
        check_eq("R3 default high width", w, 3);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            cfg_write(v[73], v[72:41]);
            repeat (80) @(negedge clk);
            check_eq(v[40] ? "R6 error set on reject" : "R7 error clear on accept",
                     err, v[40]);
            next_rise(n);
            next_rise(p);
            check_eq(v[40] ? "R6 kept period" : "R2 period", p, v[39:8]);
            high_width(w);
            check_eq("R3 high width", w, 3);
            rises_to_fetch(r, s);
            rises_to_fetch(r, s);
            check_eq("R4 edges per fetch", r, 1 << v[7:0]);
            check_eq("R5 fetch delay after edge", s, 3);
            @(negedge clk);
            check_eq("R4 fetch width", fetch, 0);
        end

        // R8 restart from idle with N=3: first fetch after 9 edges
        @(negedge clk);
        en = 1'b0;
        repeat (20) @(negedge clk);
        check_eq("R9 idle conv", conv, 0);
        en = 1'b1;
        rises_to_fetch(r, s);
        check_eq("R8 edges before first fetch N=3", r, 9);

        // R9 disable right at a conversion edge with N=0 (fetch each period)
        cfg_write(1'b1, 32'd0);
        repeat (80) @(negedge clk);
        next_rise(n);
        next_rise(p);
        check_eq("R7 period after N change", p, 1000);
        en = 1'b0;
        high_width(w);
        check_eq("R9 pulse completes after disable", w, 3);
        hits = 0;
        r = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (fetch) hits++;
            if (conv) r++;
        end
        check_eq("R9 fetch after disable", hits, 0);
        check_eq("R9 conversion after disable", r, 0);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule